// File: doc/BRIEF.md
# Dual Limit-Match Interval Timer

This block holds two independent interval timers behind one 64-bit register bus. A shared prescaler divides the system clock to make a one-microsecond tick. Each timer has a 29-bit up-counter that advances on that tick. It also has a limit register that holds a match value and three control bits. When the counter reaches the match value, the timer can latch a pending interrupt. In periodic mode the counter restarts from zero at that point. In one-shot style operation it keeps counting and wraps.

Each timer also has a clear register and a routing register. A write of any value to the clear register drops the pending flag. The routing register carries a valid bit that gates the timer's interrupt line. It also carries a target number that is passed unchanged to a side output for the downstream interrupt controller. Software that wants an interrupt every n microseconds programs a match value of n-1.

The register window uses word addresses. The timer index is taken from address bits above bit 1. Address bits 1:0 select the register within a timer: 0 = counter, 1 = limit, 2 = clear, 3 = routing. Reads are combinational from the address. Writes take effect at the clock edge on which `bus_we_i` is high.

Top module: `dual_limit_timer`

## Requirements
- R1: While reset is asserted, every register reads zero and `irq_o` and `irq_target_o` are zero.
- R2: A counter read returns the 29-bit count zero-extended to 64 bits. A counter write loads bits 28:0 and takes precedence over a tick in the same cycle.
- R3: The limit register keeps write-data bits 31:0 and reads them back zero-extended. Bit 31 is interrupt enable, bit 30 is reload, bit 29 is periodic, and bits 28:0 are the match value.
- R4: A limit write with bit 30 set forces the counter to zero. This takes precedence over a counter write and over a tick.
- R5: A tick occurs once every CLK_PER_US clocks, and each tick advances the counter by one.
- R6: In periodic mode, the tick that finds the counter equal to the match value sets it to zero, so matches recur every match+1 ticks.
- R7: With periodic mode off, the counter passes the match value and wraps from 0x1FFFFFFF to 0.
- R8: A match sets the pending flag only when bit 31 of the limit is set. A cycle that writes the counter, or writes the limit with bit 30 set, produces no match.
- R9: Pending stays set until a write to that timer's clear register. A match in the same cycle as a clear leaves it set. The clear register reads zero.
- R10: `irq_o[t]` is pending AND routing bit 31. `irq_target_o` slice t equals routing bits TGT_W-1:0.
- R11: The routing register stores only bit 31 and bits TGT_W-1:0, and reads back with all other bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_we_i | input | 1 | Write strobe for the register window |
| bus_addr_i | input | ADDR_W | Word address: timer index above bit 1, register select in bits 1:0 |
| bus_wdata_i | input | 64 | Write data |
| bus_rdata_o | output | 64 | Combinational read data for `bus_addr_i` |
| irq_o | output | NUM_TIMERS | Per-timer interrupt, gated by the routing valid bit |
| irq_target_o | output | NUM_TIMERS*TGT_W | Per-timer routing target number |

## Verification
The properties assume that `bus_we_i` and `bus_addr_i` are driven to known values after reset. They also assume that a clear is recognised only from a write strobe whose address carries register select 2 for that timer. The properties derive the clear condition from those ports, so a glitch on the address while the strobe is high would break the pending-hold check. The bench changes bus inputs only on falling clock edges, always drives a defined address, and drops the strobe one cycle after each write, so every write is a single clean bus cycle.

// File: rtl/timer_pkg.sv
`timescale 1ns/1ps
package timer_pkg;
  localparam int CNT_W         = 29;
  localparam int BUS_W         = 64;
  localparam int REG_W         = 32;
  localparam int IEN_BIT       = 31;
  localparam int RELOAD_BIT    = 30;
  localparam int PERIODIC_BIT  = 29;
  localparam int ROUTE_VLD_BIT = 31;

  typedef enum logic [1:0] {
    SEL_COUNT = 2'd0,
    SEL_LIMIT = 2'd1,
    SEL_CLEAR = 2'd2,
    SEL_ROUTE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/tmr_rst_sync.sv
`timescale 1ns/1ps
module tmr_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/tmr_prescaler.sv
`timescale 1ns/1ps
module tmr_prescaler #(
  parameter int DIV = 100,
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  logic [PW-1:0] pcnt_q, pcnt_d;
  logic          wrap;

  assign wrap = (pcnt_q == PW'(DIV - 1));

  always_comb begin
    pcnt_d = wrap ? '0 : pcnt_q + PW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pcnt_q <= '0;
    else         pcnt_q <= pcnt_d;
  end

  assign tick_o = wrap;
endmodule

// File: rtl/tmr_channel.sv
`timescale 1ns/1ps
module tmr_channel
  import timer_pkg::*;
#(
  parameter int TGT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             cnt_we_i,
  input  logic             lim_we_i,
  input  logic             clr_we_i,
  input  logic             route_we_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [REG_W-1:0] lim_o,
  output logic [REG_W-1:0] route_o,
  output logic             pend_o,
  output logic             irq_o,
  output logic [TGT_W-1:0] target_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [REG_W-1:0] lim_q, lim_d;
  logic             pend_q, pend_d;
  logic             rvld_q, rvld_d;
  logic [TGT_W-1:0] tgt_q, tgt_d;
  logic             cnt_en, lim_en, pend_en, route_en;
  logic             reload_wr, at_match, match_evt;
  logic             unused_mid;

  assign unused_mid = ^wdata_i[REG_W-2:TGT_W];

  always_comb begin
    reload_wr = lim_we_i && wdata_i[RELOAD_BIT];
    at_match  = (cnt_q == lim_q[CNT_W-1:0]);
    match_evt = tick_i && at_match && !cnt_we_i && !reload_wr;

    cnt_en = reload_wr || cnt_we_i || tick_i;
    if (reload_wr)
      cnt_d = '0;
    else if (cnt_we_i)
      cnt_d = wdata_i[CNT_W-1:0];
    else if (at_match && lim_q[PERIODIC_BIT])
      cnt_d = '0;
    else
      cnt_d = cnt_q + CNT_W'(1);

    lim_en = lim_we_i;
    lim_d  = wdata_i;

    pend_en = clr_we_i || match_evt;
    pend_d  = match_evt && lim_q[IEN_BIT];
    if (!(match_evt && lim_q[IEN_BIT]) && !clr_we_i)
      pend_d = pend_q;
    if (match_evt && !lim_q[IEN_BIT] && !clr_we_i)
      pend_d = pend_q;

    route_en = route_we_i;
    rvld_d   = wdata_i[ROUTE_VLD_BIT];
    tgt_d    = wdata_i[TGT_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      lim_q  <= '0;
      pend_q <= 1'b0;
      rvld_q <= 1'b0;
      tgt_q  <= '0;
    end else begin
      if (cnt_en)   cnt_q  <= cnt_d;
      if (lim_en)   lim_q  <= lim_d;
      if (pend_en)  pend_q <= pend_d;
      if (route_en) begin
        rvld_q <= rvld_d;
        tgt_q  <= tgt_d;
      end
    end
  end

  always_comb begin
    route_o                = '0;
    route_o[ROUTE_VLD_BIT] = rvld_q;
    route_o[TGT_W-1:0]     = tgt_q;
  end

  assign cnt_o    = cnt_q;
  assign lim_o    = lim_q;
  assign pend_o   = pend_q;
  assign irq_o    = pend_q && rvld_q;
  assign target_o = tgt_q;
endmodule

// File: rtl/dual_limit_timer.sv
`timescale 1ns/1ps
module dual_limit_timer
  import timer_pkg::*;
#(
  parameter  int NUM_TIMERS = 2,
  parameter  int CLK_PER_US = 100,
  parameter  int TGT_W      = 6,
  localparam int CH_W       = (NUM_TIMERS > 1) ? $clog2(NUM_TIMERS) : 1,
  localparam int ADDR_W     = CH_W + 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        bus_we_i,
  input  logic [ADDR_W-1:0]           bus_addr_i,
  input  logic [BUS_W-1:0]            bus_wdata_i,
  output logic [BUS_W-1:0]            bus_rdata_o,
  output logic [NUM_TIMERS-1:0]       irq_o,
  output logic [NUM_TIMERS*TGT_W-1:0] irq_target_o
);
  logic                               rst_sync_n;
  logic                               tick_w;
  logic [NUM_TIMERS-1:0]              pend_w;
  logic [NUM_TIMERS-1:0][CNT_W-1:0]   cnt_w;
  logic [NUM_TIMERS-1:0][REG_W-1:0]   lim_w;
  logic [NUM_TIMERS-1:0][REG_W-1:0]   route_w;
  logic [CH_W-1:0]                    ch_sel;
  reg_sel_e                           reg_sel;
  logic                               unused_hi;

  assign unused_hi = ^bus_wdata_i[BUS_W-1:REG_W];
  assign ch_sel    = bus_addr_i[ADDR_W-1:2];
  assign reg_sel   = reg_sel_e'(bus_addr_i[1:0]);

  tmr_rst_sync u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_sync_n)
  );

  tmr_prescaler #(.DIV(CLK_PER_US)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .tick_o (tick_w)
  );

  for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_ch
    logic hit;
    assign hit = bus_we_i && (ch_sel == CH_W'(t));

    tmr_channel #(.TGT_W(TGT_W)) u_ch (
      .clk_i      (clk_i),
      .rst_ni     (rst_sync_n),
      .tick_i     (tick_w),
      .cnt_we_i   (hit && (reg_sel == SEL_COUNT)),
      .lim_we_i   (hit && (reg_sel == SEL_LIMIT)),
      .clr_we_i   (hit && (reg_sel == SEL_CLEAR)),
      .route_we_i (hit && (reg_sel == SEL_ROUTE)),
      .wdata_i    (bus_wdata_i[REG_W-1:0]),
      .cnt_o      (cnt_w[t]),
      .lim_o      (lim_w[t]),
      .route_o    (route_w[t]),
      .pend_o     (pend_w[t]),
      .irq_o      (irq_o[t]),
      .target_o   (irq_target_o[t*TGT_W +: TGT_W])
    );
  end

  always_comb begin
    bus_rdata_o = '0;
    for (int t = 0; t < NUM_TIMERS; t++) begin
      if (ch_sel == CH_W'(t)) begin
        case (reg_sel)
          SEL_COUNT: bus_rdata_o = BUS_W'(cnt_w[t]);
          SEL_LIMIT: bus_rdata_o = BUS_W'(lim_w[t]);
          SEL_ROUTE: bus_rdata_o = BUS_W'(route_w[t]);
          default:   bus_rdata_o = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/dual_limit_timer_chk.sv
`timescale 1ns/1ps
module dual_limit_timer_chk #(
  parameter int NUM = 2,
  parameter int DIV = 100,
  parameter int AW  = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bus_we,
  input logic [AW-1:0]  bus_addr,
  input logic [NUM-1:0] irq,
  input logic [NUM-1:0] pend,
  input logic           tick
);
  // R1
  always @(posedge clk) begin
    if (!rst_n) begin
      rst_quiet_chk: assert (irq == '0);
    end
  end

  if (DIV > 1) begin : g_gap
    // R5
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
  end

  for (genvar t = 0; t < NUM; t++) begin : g_t
    logic clr_hit;
    assign clr_hit = bus_we && (bus_addr == AW'(t*4 + 2));

    // R10
    irq_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq[t] |-> pend[t]);

    // R9
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend[t] && !clr_hit) |=> pend[t]);

    // R8
    pend_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend[t]) |-> $past(tick));
  end
endmodule

bind dual_limit_timer dual_limit_timer_chk #(
  .NUM (NUM_TIMERS),
  .DIV (CLK_PER_US),
  .AW  (ADDR_W)
) chk_i (
  .clk      (clk_i),
  .rst_n    (rst_ni),
  .bus_we   (bus_we_i),
  .bus_addr (bus_addr_i),
  .irq      (irq_o),
  .pend     (pend_w),
  .tick     (tick_w)
);

// File: tb/dual_limit_timer_tb_top.sv
`timescale 1ns/1ps
module dual_limit_timer_tb_top;
  localparam int DIV  = 4;
  localparam int TGTW = 6;
  localparam int AW   = 3;
  localparam int NV   = 7;

  // {addr, write data, expected readback}
  localparam logic [130:0] VEC [NV] = '{
    {3'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_1FFF_FFFF},  // R2
    {3'd0, 64'h0000_0000_0000_1234, 64'h0000_0000_0000_1234},  // R2
    {3'd1, 64'hABCD_0000_9000_0010, 64'h0000_0000_9000_0010},  // R3
    {3'd3, 64'hFFFF_FFFF_7FFF_FFC5, 64'h0000_0000_0000_0005},  // R11
    {3'd5, 64'h0000_0000_2000_0007, 64'h0000_0000_2000_0007},  // R3
    {3'd7, 64'h0000_0000_8000_0021, 64'h0000_0000_8000_0021},  // R11
    {3'd2, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_0000}   // R9
  };

  logic                 clk;
  logic                 rst_n;
  logic                 we;
  logic [AW-1:0]        addr;
  logic [63:0]          wdata;
  logic [63:0]          rdata;
  logic [1:0]           irq;
  logic [2*TGTW-1:0]    tgt;
  int                   checks;
  int                   fails;
  longint               cyc;

  dual_limit_timer #(.NUM_TIMERS(2), .CLK_PER_US(DIV), .TGT_W(TGTW)) dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .bus_we_i     (we),
    .bus_addr_i   (addr),
    .bus_wdata_i  (wdata),
    .bus_rdata_o  (rdata),
    .irq_o        (irq),
    .irq_target_o (tgt)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  initial cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [AW-1:0] a, input logic [63:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic bus_rd(input logic [AW-1:0] a, output logic [63:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic wait_rise(input int idx, output longint at);
    at = -1;
    for (int k = 0; k < 500; k++) begin
      @(negedge clk);
      if (irq[idx]) begin
        at = cyc;
        break;
      end
    end
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [63:0] r;
    longint t1, t2;
    checks = 0; fails = 0;
    we = 1'b0; addr = '0; wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);

    // R1: reset state
    for (int a = 0; a < 8; a++) begin
      bus_rd(AW'(a), r);
      check("R1 reg read", r, 64'h0);
    end
    check("R1 irq", 64'(irq), 64'h0);
    check("R1 target", 64'(tgt), 64'h0);

    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Table walk: write then immediate readback
    for (int i = 0; i < NV; i++) begin
      bus_wr(VEC[i][130:128], VEC[i][127:64]);
      bus_rd(VEC[i][130:128], r);
      check($sformatf("R2/R3/R9/R11 vector %0d", i), r, VEC[i][63:0]);
    end
    check("R10 target passthrough", 64'(tgt[TGTW +: TGTW]), 64'h21);
    check("R8 no irq with enable off", 64'(irq[1]), 64'h0);

    // fresh start
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R6 / R8 / R10: periodic period of match+1 ticks
    bus_wr(3'd3, 64'h8000_0003);
    bus_wr(3'd1, 64'hE000_0004);
    wait_rise(0, t1);
    check("R8 first match raises irq", 64'(t1 >= 0), 64'h1);
    check("R10 target timer0", 64'(tgt[0 +: TGTW]), 64'h3);
    bus_wr(3'd2, 64'h0);
    check("R9 clear drops irq", 64'(irq[0]), 64'h0);
    wait_rise(0, t2);
    check("R6 period cycles", 64'(t2 - t1), 64'(5 * DIV));

    // R5: tick rate
    bus_wr(3'd5, 64'h0);
    bus_wr(3'd4, 64'h0);
    repeat (8 * DIV) @(negedge clk);
    bus_rd(3'd4, r);
    check("R5 eight ticks", r, 64'd8);

    // R7: wrap and run past limit
    bus_wr(3'd5, 64'h0000_0002);
    bus_wr(3'd4, 64'h1FFF_FFFF);
    repeat (DIV) @(negedge clk);
    bus_rd(3'd4, r);
    check("R7 wrap to zero", r, 64'd0);
    repeat (5 * DIV) @(negedge clk);
    bus_rd(3'd4, r);
    check("R7 past limit", r, 64'd5);

    // R4: reload
    bus_wr(3'd5, 64'h4000_0000);
    bus_rd(3'd4, r);
    check("R4 reload clears count", r, 64'd0);

    // R8: enable gating
    bus_wr(3'd7, 64'h8000_0000);
    bus_wr(3'd5, 64'h6000_0001);
    repeat (40) @(negedge clk);
    check("R8 enable off no irq", 64'(irq[1]), 64'h0);
    bus_wr(3'd5, 64'hA000_0001);
    repeat (12) @(negedge clk);
    check("R8 enable on irq", 64'(irq[1]), 64'h1);

    // R10 / R9: routing gate and held pending
    bus_wr(3'd7, 64'h0);
    check("R10 route invalid masks irq", 64'(irq[1]), 64'h0);
    bus_wr(3'd7, 64'h8000_0000);
    check("R9 pending held under mask", 64'(irq[1]), 64'h1);
    bus_wr(3'd5, 64'h2000_0001);
    bus_wr(3'd6, 64'h0);
    check("R9 clear timer1", 64'(irq[1]), 64'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule